// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Global Mask

This block picks which exception a processor core should take next. It holds a 2-bit urgency level for each of `NUM_IRQ` interrupt lines. The levels are packed four to a 32-bit word, so software can load them with word writes. The block also holds a single global mask bit.

Each cycle it registers three inputs: the vector of enabled-and-pending interrupt lines, a pending bit for the non-maskable interrupt, and the core's current execution level. From those registered values it forms a combinational result. It reports the exception number of the most urgent pending request, a flag that something is pending, and a request that the winner should take over the core now.

The core or its bus fabric drives the write port. It samples `pend_vec` and `preempt_req` to decide on exception entry. Handler execution, stacking and exception return timing belong to the surrounding logic.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, every stored level is 0, the mask bit is 0, and `pend_vec`, `pend_any` and `preempt_req` are all 0.
- R2: A write with byte address 0x400+4k (k from 0 to NUM_IRQ/4-1) stores bits [8b+7:8b+6] of the data as the level of IRQ 4k+b. A read of that address returns each level in bits [8b+7:8b+6] and zero in every other bit.
- R3: Writes to any address other than the level words and the mask word (0x420) leave all state unchanged, and reads of such addresses return 0. Addresses that are not word aligned count as other addresses.
- R4: With no NMI pending, `pend_vec` equals 16 plus the index of the winning IRQ. The winner is the pending IRQ with the numerically lowest level, and a tie goes to the lower index.
- R5: A pending NMI drives `pend_vec` to 2 and `preempt_req` to 1, regardless of the mask and the current level.
- R6: With no IRQ and no NMI pending, `pend_vec` is 0 and `pend_any` and `preempt_req` are 0.
- R7: `cur_level` values 0 to 3 are execution levels, and 4 to 7 mean thread mode, which is less urgent than any level. An IRQ winner raises `preempt_req` only when its level is strictly lower than the current level, so an equal level waits.
- R8: Bit 0 of the word at 0x420 is the mask, and reading that word returns it. When the mask is 1, the effective current level is 0, so no IRQ can preempt. The mask keeps its value until software writes it again.
- R9: The outputs follow the pending inputs, the NMI input, `cur_level` and register writes that were sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| irq_pend | input | NUM_IRQ | Enabled-and-pending interrupt lines |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| cur_level | input | 3 | Current execution level (4 to 7 = thread mode) |
| pend_vec | output | 6 | Exception number of the winner (0 = none) |
| pend_any | output | 1 | Some exception is pending |
| preempt_req | output | 1 | The winner may take over the core now |

## Verification
The hardest case to reach from the ports is a tie: two pending lines at the same level must resolve by index, and a winner whose level equals the current level must not preempt. To reach it, the bench loads a level pattern that repeats every four lines. It then sweeps every ordered pair of pending lines against all five distinct current levels, which yields thousands of ties and boundary comparisons. After that it applies pseudo-random multi-line pending vectors under a second level pattern, then checks the mask and NMI overrides on top of a pending line at the most urgent level.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    localparam int LVL_W  = 2;
    localparam int CUR_W  = 3;
    localparam int VEC_W  = 6;
    localparam int IRQ_EXC_BASE = 16;
    localparam int NMI_EXC_NUM  = 2;
    localparam int THREAD_LVL   = 4;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CUR_W-1:0] cur_t;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/ipa_prio_regs.sv
module ipa_prio_regs
    import ipa_pkg::*;
#(
    parameter int NUM_IRQ  = 32,
    parameter int ADDR_W   = 12,
    parameter int LVL_BASE = 'h400,
    parameter int MASK_OFS = 'h420
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [31:0]             rd_data,
    output logic [NUM_IRQ*LVL_W-1:0] lvl_flat,
    output logic                    mask_q
);
    localparam int WORDS  = NUM_IRQ / 4;
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(LVL_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(LVL_BASE + 4 * WORDS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic [ADDR_W-1:0] wr_off, rd_off;
    logic              wr_word_hit, rd_word_hit, wr_mask_hit;
    logic [WIDX_W-1:0] wr_idx, rd_idx;
    lvl_t              lvl_q [NUM_IRQ];

    always_comb begin
        wr_off      = wr_addr - BASE_A;
        rd_off      = rd_addr - BASE_A;
        wr_idx      = wr_off[WIDX_W+1:2];
        rd_idx      = rd_off[WIDX_W+1:2];
        wr_word_hit = wr_en && (wr_addr[1:0] == 2'b00) && (wr_addr >= BASE_A) && (wr_addr < END_A);
        rd_word_hit = (rd_addr[1:0] == 2'b00) && (rd_addr >= BASE_A) && (rd_addr < END_A);
        wr_mask_hit = wr_en && (wr_addr == MASK_A);
    end

    // One level register per interrupt line; byte lane picks the field.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[g] <= '0;
            end else if (wr_word_hit && (wr_idx == WIDX_W'(g / 4))) begin
                lvl_q[g] <= wr_data[8*(g%4)+7 -: LVL_W];
            end
        end
        assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_mask_hit) begin
            mask_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_word_hit) begin
            for (int g = 0; g < NUM_IRQ; g++) begin
                if (rd_idx == WIDX_W'(g / 4)) begin
                    rd_data[8*(g%4)+7 -: LVL_W] = lvl_q[g];
                end
            end
        end else if (rd_addr == MASK_A) begin
            rd_data[0] = mask_q;
        end
    end

    // R3
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_word_hit && !wr_mask_hit) |=> ($stable(lvl_flat) && $stable(mask_q)));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_hit |=> $stable(mask_q));
endmodule

// File: rtl/ipa_select.sv
module ipa_select
    import ipa_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       pend,
    input  logic [NUM_IRQ*LVL_W-1:0] lvl_flat,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx,
    output lvl_t                     win_lvl
);
    // Linear scan: strict compare keeps the lowest index on ties.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!found || (lvl_flat[i*LVL_W +: LVL_W] < win_lvl))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    // R4
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pend[win_idx]);

    // R6
    none_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (pend == '0));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import ipa_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               nmi_pend,
    input  logic [2:0]         cur_level,
    output logic [5:0]         pend_vec,
    output logic               pend_any,
    output logic               preempt_req
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0]       pend_q;
    logic                     nmi_q;
    cur_t                     cur_q;
    logic [NUM_IRQ*LVL_W-1:0] lvl_flat;
    logic                     mask_q;
    logic                     found;
    logic [IDX_W-1:0]         win_idx;
    lvl_t                     win_lvl;
    cur_t                     eff_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            nmi_q  <= 1'b0;
            cur_q  <= cur_t'(THREAD_LVL);
        end else begin
            pend_q <= irq_pend;
            nmi_q  <= nmi_pend;
            cur_q  <= cur_level;
        end
    end

    ipa_prio_regs #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lvl_flat (lvl_flat),
        .mask_q   (mask_q)
    );

    ipa_select #(
        .NUM_IRQ (NUM_IRQ),
        .IDX_W   (IDX_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_q),
        .lvl_flat (lvl_flat),
        .found    (found),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    always_comb begin
        if (mask_q)        eff_lvl = '0;
        else if (cur_q[2]) eff_lvl = cur_t'(THREAD_LVL);
        else               eff_lvl = cur_q;

        pend_any = nmi_q | found;
        if (nmi_q) begin
            pend_vec    = 6'(NMI_EXC_NUM);
            preempt_req = 1'b1;
        end else if (found) begin
            pend_vec    = 6'(IRQ_EXC_BASE) + 6'(win_idx);
            preempt_req = ({1'b0, win_lvl} < eff_lvl);
        end else begin
            pend_vec    = '0;
            preempt_req = 1'b0;
        end
    end

    // R5
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |-> (pend_vec == 6'd2 && preempt_req));

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |-> (pend_vec == 6'd0 && !preempt_req));

    // R7
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_q && !mask_q && cur_q == 3'd0) |-> !preempt_req);

    // R8
    masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !nmi_q) |-> !preempt_req);

    // R9
    nmi_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(nmi_pend)) |-> (pend_vec == 6'd2));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] irq_pend = '0;
    logic        nmi_pend = 1'b0;
    logic [2:0]  cur_level = 3'd4;
    logic [5:0]  pend_vec;
    logic        pend_any;
    logic        preempt_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int model_lvl [N];

    always #2.5 clk = ~clk;

    irq_prio_arbiter #(.NUM_IRQ(N), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_pend(irq_pend), .nmi_pend(nmi_pend), .cur_level(cur_level),
        .pend_vec(pend_vec), .pend_any(pend_any), .preempt_req(preempt_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic apply(input logic [N-1:0] p, input logic nmi, input logic [2:0] cur);
        @(negedge clk);
        irq_pend = p; nmi_pend = nmi; cur_level = cur;
        @(posedge clk);
        #1;
    endtask

    // Loads levels from a pattern via word writes and records them in the model.
    task automatic load_pattern(input int sel);
        for (int w = 0; w < N / 4; w++) begin
            logic [31:0] d;
            d = $urandom;
            for (int b = 0; b < 4; b++) begin
                int i;
                i = 4 * w + b;
                model_lvl[i] = (sel == 0) ? (i * 7 + 3) % 4 : (i * 5 + i / 4) % 4;
                d[8*b+7 -: 2] = 2'(model_lvl[i]);
            end
            wr(12'h400 + 12'(4 * w), d);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] d;
        d = '0;
        for (int b = 0; b < 4; b++) d[8*b+7 -: 2] = 2'(model_lvl[4*w+b]);
        return d;
    endfunction

    // Expected {pend_any, preempt, vec}, computed from the requirements.
    function automatic logic [7:0] expect_out(input logic [N-1:0] p, input logic nmi,
                                              input logic [2:0] cur, input logic msk);
        int best, bidx, eff;
        logic pre;
        if (nmi) return {1'b1, 1'b1, 6'd2};
        best = 99; bidx = -1;
        for (int i = 0; i < N; i++)
            if (p[i] && model_lvl[i] < best) begin best = model_lvl[i]; bidx = i; end
        if (bidx < 0) return 8'h00;
        eff = msk ? 0 : (cur >= 3'd4 ? 4 : int'(cur));
        pre = (best < eff);
        return {1'b1, pre, 6'(16 + bidx)};
    endfunction

    initial begin
        logic [31:0] d;
        logic [N-1:0] p;
        logic [31:0] lfsr;
        int curv;

        for (int i = 0; i < N; i++) model_lvl[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1: reset state
        check("R1 outputs", {24'd0, pend_any, preempt_req, pend_vec}, 32'd0);
        for (int w = 0; w < N / 4; w++) begin
            rd(12'h400 + 12'(4 * w), d);
            check("R1 level word", d, 32'd0);
        end
        rd(12'h420, d);
        check("R1 mask", d, 32'd0);

        // R2: only the top two bits of each byte are kept
        wr(12'h404, 32'hFFFF_FFFF);
        rd(12'h404, d);
        check("R2 all ones", d, 32'hC0C0_C0C0);
        wr(12'h404, 32'h3F7F_BF00);
        rd(12'h404, d);
        check("R2 mixed", d, 32'h0040_8000);

        load_pattern(0);
        for (int w = 0; w < N / 4; w++) begin
            rd(12'h400 + 12'(4 * w), d);
            check("R2 readback", d, exp_word(w));
        end

        // R3: stray and misaligned writes change nothing, stray reads are 0
        wr(12'h500, 32'hFFFF_FFFF);
        wr(12'h402, 32'hFFFF_FFFF);
        wr(12'h3FC, 32'hFFFF_FFFF);
        wr(12'h421, 32'h0000_0001);
        for (int w = 0; w < N / 4; w++) begin
            rd(12'h400 + 12'(4 * w), d);
            check("R3 levels kept", d, exp_word(w));
        end
        rd(12'h420, d);
        check("R3 mask kept", d, 32'd0);
        rd(12'h500, d);
        check("R3 stray read", d, 32'd0);

        // R6: nothing pending
        apply('0, 1'b0, 3'd4);
        check("R6 idle", {24'd0, pend_any, preempt_req, pend_vec}, 32'd0);

        // R4 R7 R9: all ordered pairs against every current level
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                for (int c = 0; c < 5; c++) begin
                    p = '0; p[i] = 1'b1; p[j] = 1'b1;
                    apply(p, 1'b0, 3'(c));
                    check("R4/R7 pair", {24'd0, pend_any, preempt_req, pend_vec},
                          {24'd0, expect_out(p, 1'b0, 3'(c), 1'b0)});
                end
            end
        end

        // R7: thread-mode encodings 5..7 behave like 4
        for (int c = 5; c < 8; c++) begin
            p = '0; p[3] = 1'b1;
            apply(p, 1'b0, 3'(c));
            check("R7 thread code", {31'd0, preempt_req}, 32'd1);
        end

        // R4: random multi-line vectors under a second pattern
        load_pattern(1);
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            p = N'(lfsr & {lfsr[15:0], lfsr[31:16]});
            curv = k % 6;
            apply(p, 1'b0, 3'(curv));
            check("R4 random", {24'd0, pend_any, preempt_req, pend_vec},
                  {24'd0, expect_out(p, 1'b0, 3'(curv), 1'b0)});
        end

        // R8: mask blocks IRQ preemption, readable, persists
        wr(12'h000, 32'd0);
        p = '0; p[0] = 1'b1;
        wr(12'h400, 32'h0000_0000);
        model_lvl[0] = 0;
        wr(12'h420, 32'h0000_0001);
        rd(12'h420, d);
        check("R8 mask read", d, 32'd1);
        apply(p, 1'b0, 3'd4);
        check("R8 masked", {24'd0, pend_any, preempt_req, pend_vec},
              {24'd0, expect_out(p, 1'b0, 3'd4, 1'b1)});
        repeat (5) apply(p, 1'b0, 3'd4);
        check("R8 still masked", {31'd0, preempt_req}, 32'd0);

        // R5: NMI overrides mask and levels
        apply(p, 1'b1, 3'd0);
        check("R5 nmi masked", {24'd0, pend_any, preempt_req, pend_vec}, {24'd0, 8'hC2});
        wr(12'h420, 32'h0000_0000);
        apply('0, 1'b1, 3'd4);
        check("R5 nmi alone", {24'd0, pend_any, preempt_req, pend_vec}, {24'd0, 8'hC2});

        apply(p, 1'b0, 3'd4);
        check("R8 unmasked", {31'd0, preempt_req}, 32'd1);

        // R9: outputs follow inputs one edge later
        @(negedge clk);
        irq_pend = '0; nmi_pend = 1'b0;
        #1;
        check("R9 before edge", {26'd0, pend_vec}, 32'd16);
        @(posedge clk);
        #1;
        check("R9 after edge", {26'd0, pend_vec}, 32'd0);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule